// File: doc/BRIEF.md
# Flash Command-Sequence Controller

This block models the write side of a parallel NOR flash: it watches host bus cycles, recognises unlock and command sequences, and runs word-program and sector-erase operations on a small internal array. Each operation takes a configurable number of clock cycles. While an operation runs, the read data path returns a status word in place of array data. The host polls this word to learn when the operation has finished.

Four further behaviours share one bus. A bypass mode shortens programming to two write cycles. Erase and program can be paused and continued. A write-protect pin guards one boundary sector. A hardware reset aborts any operation. The bus strobes (chip enable, write enable, output enable) are active low and sampled in the controller clock domain. The data bus is split into a write input and a read output.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After power-up every word reads 16'hFFFF. When the chip is idle, a read returns the stored word. `rdata` is 16'h0000 whenever `ce_n` or `oe_n` is high.
- R2: A bus write is taken on the rising edge of `we_n` with `ce_n` low. The sequence 8'hAA at address 'h555, 8'h55 at 'h2AA, 8'hA0 at 'h555, then data at the target address programs that word. Addresses are compared on their low AW bits, and only the low byte of a command word is decoded. PROG_CYCLES cycles after the last write, the stored word becomes the old value ANDed with the new data.
- R3: A write that does not match the next expected step of a sequence returns the decoder to its idle state. The array is not changed and no operation starts.
- R4: The writes AA/55 followed by 8'h20 at 'h555 enter bypass mode. In bypass mode, 8'hA0 at any address followed by data at the target programs the word. The writes 8'h90 then 8'h00 leave bypass mode, after which a two-write program has no effect.
- R5: The writes AA, 55, 8'h80, AA, 55, then 8'h30 at any address of a sector erase that sector. ERASE_CYCLES later every word of the sector is 16'hFFFF, and all other sectors are unchanged.
- R6: While an operation runs, a read at any address returns a status word. Bits 15:8 and 5:0 are zero. Bit 7 is the complement of bit 7 of the program data, and is 0 for an erase.
- R7: Bit 6 of the status word inverts after each completed read while an operation runs. It holds its value while no operation runs, including while an operation is suspended.
- R8: Writing 8'hB0 during a running erase suspends it. A read of the erasing sector then returns status. A read of any other sector returns array data. A program to another sector may run and complete while the erase is suspended.
- R9: Writing 8'h30 while an erase is suspended and no program is active resumes the erase, which then completes.
- R10: Writing 8'hB0 during a running program (with no erase active) suspends the program. Reads of other sectors then return array data, and reads of the target sector return status. Writing 8'h30 resumes the program, which then completes.
- R11: While `wp_n` is low, a program or erase aimed at the protected sector shows busy status for PROT_CYCLES cycles. The array is then left unchanged. The protected sector is sector 0 when WP_LAST=0 and the last sector when WP_LAST=1. Other sectors are unaffected by `wp_n`.
- R12: Driving `rst_n` low aborts any operation and leaves the array unchanged. It also clears the sequence state and bypass mode. After release, new commands are accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write strobe, active low; cycle taken on its rising edge |
| oe_n | input | 1 | Output enable, active low |
| wp_n | input | 1 | Write protect for the boundary sector, active low |
| addr | input | AW | Word address |
| wdata | input | 16 | Write data / command word |
| rdata | output | 16 | Array data or status word |

## Verification
A wrong slot state shows on the very next read. If the controller believes it is busy, reads return a status word where the array word is expected. If it believes it is idle, reads return array data where status belongs. A timer or commit fault shows only after the expected operation time has passed: the word is never updated, a protected word changes, or the value is not the AND of old and new. The bench therefore sweeps every word of every sector after each operation. A toggle or suspend fault shows within two consecutive reads, through the status bit 6 comparison.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

   typedef enum logic [3:0] {
      SQ_IDLE, SQ_U1, SQ_U2, SQ_PGM,
      SQ_E1, SQ_E2, SQ_E3,
      SQ_BYP, SQ_BPGM, SQ_BEXIT
   } seq_e;

   localparam logic [7:0] C_UNLK1  = 8'hAA;
   localparam logic [7:0] C_UNLK2  = 8'h55;
   localparam logic [7:0] C_PROG   = 8'hA0;
   localparam logic [7:0] C_ESETUP = 8'h80;
   localparam logic [7:0] C_ERASE  = 8'h30;
   localparam logic [7:0] C_BYPASS = 8'h20;
   localparam logic [7:0] C_BEXIT1 = 8'h90;
   localparam logic [7:0] C_BEXIT2 = 8'h00;
   localparam logic [7:0] C_SUSP   = 8'hB0;
   localparam logic [7:0] C_RESUME = 8'h30;

   function automatic logic [15:0] status_word(input logic inv7, input logic tog);
      return {8'h00, inv7, tog, 6'b000000};
   endfunction

endpackage

// File: rtl/flash_seq_decode.sv
module flash_seq_decode
   import flash_cmd_pkg::*;
#(
   parameter int AW = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_stb,
   input  logic [AW-1:0] wr_addr,
   input  logic [7:0]    wr_byte,
   input  logic          op_running,
   input  logic          can_resume,
   output logic          pgm_go,
   output logic          ers_go,
   output logic          sus_go,
   output logic          res_go
);
   localparam logic [AW-1:0] ADDR_A = AW'(11'h555);
   localparam logic [AW-1:0] ADDR_B = AW'(11'h2AA);

   seq_e st_q, st_d;

   logic hit_u1, hit_u2, at_a;
   assign hit_u1 = (wr_addr == ADDR_A) && (wr_byte == C_UNLK1);
   assign hit_u2 = (wr_addr == ADDR_B) && (wr_byte == C_UNLK2);
   assign at_a   = (wr_addr == ADDR_A);

   always_comb begin
      st_d   = st_q;
      pgm_go = 1'b0;
      ers_go = 1'b0;
      sus_go = 1'b0;
      res_go = 1'b0;
      if (wr_stb) begin
         if (op_running) begin
            sus_go = (wr_byte == C_SUSP);
         end else begin
            case (st_q)
               SQ_IDLE: begin
                  if (hit_u1) st_d = SQ_U1;
                  else if (wr_byte == C_RESUME && can_resume) res_go = 1'b1;
               end
               SQ_U1: st_d = hit_u2 ? SQ_U2 : SQ_IDLE;
               SQ_U2: begin
                  if (at_a && wr_byte == C_PROG)        st_d = SQ_PGM;
                  else if (at_a && wr_byte == C_ESETUP) st_d = SQ_E1;
                  else if (at_a && wr_byte == C_BYPASS) st_d = SQ_BYP;
                  else                                  st_d = SQ_IDLE;
               end
               SQ_PGM: begin
                  pgm_go = 1'b1;
                  st_d   = SQ_IDLE;
               end
               SQ_E1: st_d = hit_u1 ? SQ_E2 : SQ_IDLE;
               SQ_E2: st_d = hit_u2 ? SQ_E3 : SQ_IDLE;
               SQ_E3: begin
                  ers_go = (wr_byte == C_ERASE);
                  st_d   = SQ_IDLE;
               end
               SQ_BYP: begin
                  if (wr_byte == C_PROG)        st_d = SQ_BPGM;
                  else if (wr_byte == C_BEXIT1) st_d = SQ_BEXIT;
                  else if (wr_byte == C_RESUME && can_resume) res_go = 1'b1;
               end
               SQ_BPGM: begin
                  pgm_go = 1'b1;
                  st_d   = SQ_BYP;
               end
               SQ_BEXIT: st_d = (wr_byte == C_BEXIT2) ? SQ_IDLE : SQ_BYP;
               default: st_d = SQ_IDLE;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= SQ_IDLE;
      else        st_q <= st_d;
   end

endmodule

// File: rtl/flash_op_timer.sv
module flash_op_timer #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   input  logic          run,
   output logic          done
);
   logic [CW-1:0] cnt_q;

   assign done = run && (cnt_q == CW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     cnt_q <= '0;
      else if (load)                  cnt_q <= load_val;
      else if (run && cnt_q != '0)    cnt_q <= cnt_q - CW'(1);
   end

endmodule

// File: rtl/flash_array.sv
module flash_array #(
   parameter int SECTORS      = 8,
   parameter int SECTOR_WORDS = 16,
   localparam int WORDS = SECTORS * SECTOR_WORDS,
   localparam int AW    = $clog2(WORDS),
   localparam int SECW  = $clog2(SECTORS)
) (
   input  logic            clk,
   input  logic            pgm_we,
   input  logic [AW-1:0]   pgm_addr,
   input  logic [15:0]     pgm_data,
   input  logic            ers_we,
   input  logic [SECW-1:0] ers_sector,
   input  logic [AW-1:0]   rd_addr,
   output logic [15:0]     rd_data
);
   logic [15:0] words [WORDS];

   for (genvar i = 0; i < WORDS; i++) begin : g_word
      localparam logic [SECW-1:0] MY_SEC  = SECW'(i / SECTOR_WORDS);
      localparam logic [AW-1:0]   MY_ADDR = AW'(i);
      logic [15:0] word_q = 16'hFFFF;
      always_ff @(posedge clk) begin
         if (ers_we && ers_sector == MY_SEC)       word_q <= 16'hFFFF;
         else if (pgm_we && pgm_addr == MY_ADDR)   word_q <= word_q & pgm_data;
      end
      assign words[i] = word_q;
   end

   assign rd_data = words[rd_addr];

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
   import flash_cmd_pkg::*;
#(
   parameter int SECTORS      = 8,
   parameter int SECTOR_WORDS = 16,
   parameter int PROG_CYCLES  = 16,
   parameter int ERASE_CYCLES = 64,
   parameter int PROT_CYCLES  = 4,
   parameter bit WP_LAST      = 1'b0,
   localparam int AW = $clog2(SECTORS * SECTOR_WORDS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ce_n,
   input  logic          we_n,
   input  logic          oe_n,
   input  logic          wp_n,
   input  logic [AW-1:0] addr,
   input  logic [15:0]   wdata,
   output logic [15:0]   rdata
);
   localparam int SW   = $clog2(SECTOR_WORDS);
   localparam int SECW = $clog2(SECTORS);
   localparam int MAXC = (ERASE_CYCLES > PROG_CYCLES)
                         ? ((ERASE_CYCLES > PROT_CYCLES) ? ERASE_CYCLES : PROT_CYCLES)
                         : ((PROG_CYCLES > PROT_CYCLES) ? PROG_CYCLES : PROT_CYCLES);
   localparam int CW   = $clog2(MAXC + 1);

   // elaboration checks
   if (SECTORS < 2 || (SECTORS & (SECTORS - 1)) != 0) begin : g_bad_sectors
      $error("SECTORS must be a power of two and at least 2");
   end
   if (SECTOR_WORDS < 2 || (SECTOR_WORDS & (SECTOR_WORDS - 1)) != 0) begin : g_bad_words
      $error("SECTOR_WORDS must be a power of two and at least 2");
   end
   if (PROG_CYCLES < 1 || ERASE_CYCLES < 1 || PROT_CYCLES < 1) begin : g_bad_cycles
      $error("operation cycle counts must be at least 1");
   end
   if (AW > 22) begin : g_bad_aw
      $error("address width too large");
   end

   // bus edge detection
   logic we_q, ce_q, oe_q;
   logic wr_stb, rd_end;
   assign wr_stb = we_n && !we_q && !ce_q;
   assign rd_end = oe_n && !oe_q && !ce_q;

   // protected sector choice
   logic [SECW-1:0] prot_sec;
   if (WP_LAST) begin : g_prot_last
      assign prot_sec = SECW'(SECTORS - 1);
   end else begin : g_prot_first
      assign prot_sec = '0;
   end

   logic [SECW-1:0] wr_sec, rd_sec;
   assign wr_sec = addr[AW-1:SW];
   assign rd_sec = addr[AW-1:SW];

   logic blk_w;
   assign blk_w = !wp_n && (wr_sec == prot_sec);

   // operation slots
   logic            pg_act, pg_sus, pg_blk;
   logic [AW-1:0]   pg_addr;
   logic [15:0]     pg_data;
   logic            er_act, er_sus, er_blk;
   logic [SECW-1:0] er_sec;
   logic            tog;

   logic pg_run, er_run, any_run, can_resume;
   assign pg_run     = pg_act && !pg_sus;
   assign er_run     = er_act && !er_sus;
   assign any_run    = pg_run || er_run;
   assign can_resume = (pg_act && pg_sus) || (er_act && er_sus && !pg_act);

   logic pgm_go, ers_go, sus_go, res_go;

   flash_seq_decode #(.AW(AW)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_stb     (wr_stb),
      .wr_addr    (addr),
      .wr_byte    (wdata[7:0]),
      .op_running (any_run),
      .can_resume (can_resume),
      .pgm_go     (pgm_go),
      .ers_go     (ers_go),
      .sus_go     (sus_go),
      .res_go     (res_go)
   );

   logic pg_start, er_start;
   assign pg_start = pgm_go && !pg_act && (!er_act || (er_sus && wr_sec != er_sec));
   assign er_start = ers_go && !pg_act && !er_act;

   logic pg_done, er_done;

   flash_op_timer #(.CW(CW)) u_pg_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (pg_start),
      .load_val (blk_w ? CW'(PROT_CYCLES) : CW'(PROG_CYCLES)),
      .run      (pg_run),
      .done     (pg_done)
   );

   flash_op_timer #(.CW(CW)) u_er_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (er_start),
      .load_val (blk_w ? CW'(PROT_CYCLES) : CW'(ERASE_CYCLES)),
      .run      (er_run),
      .done     (er_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_q <= 1'b1; ce_q <= 1'b1; oe_q <= 1'b1;
         pg_act <= 1'b0; pg_sus <= 1'b0; pg_blk <= 1'b0;
         pg_addr <= '0; pg_data <= '0;
         er_act <= 1'b0; er_sus <= 1'b0; er_blk <= 1'b0; er_sec <= '0;
         tog <= 1'b0;
      end else begin
         we_q <= we_n; ce_q <= ce_n; oe_q <= oe_n;
         if (rd_end && any_run) tog <= !tog;
         if (pg_start) begin
            pg_act <= 1'b1; pg_sus <= 1'b0; pg_blk <= blk_w;
            pg_addr <= addr; pg_data <= wdata;
         end else if (pg_done) begin
            pg_act <= 1'b0;
         end
         if (er_start) begin
            er_act <= 1'b1; er_sus <= 1'b0; er_blk <= blk_w; er_sec <= wr_sec;
         end else if (er_done) begin
            er_act <= 1'b0;
         end
         if (sus_go) begin
            if (pg_run && !er_act) pg_sus <= 1'b1;
            else if (er_run)       er_sus <= 1'b1;
         end
         if (res_go) begin
            if (pg_act && pg_sus)                    pg_sus <= 1'b0;
            else if (er_act && er_sus && !pg_act)    er_sus <= 1'b0;
         end
      end
   end

   logic [15:0] arr_rd;

   flash_array #(.SECTORS(SECTORS), .SECTOR_WORDS(SECTOR_WORDS)) u_arr (
      .clk        (clk),
      .pgm_we     (pg_done && !pg_blk),
      .pgm_addr   (pg_addr),
      .pgm_data   (pg_data),
      .ers_we     (er_done && !er_blk),
      .ers_sector (er_sec),
      .rd_addr    (addr),
      .rd_data    (arr_rd)
   );

   logic [SECW-1:0] pg_sec;
   assign pg_sec = pg_addr[AW-1:SW];

   always_comb begin
      if (ce_n || oe_n)
         rdata = 16'h0000;
      else if (pg_run)
         rdata = status_word(!pg_data[7], tog);
      else if (er_run)
         rdata = status_word(1'b0, tog);
      else if (pg_act && pg_sus && rd_sec == pg_sec)
         rdata = status_word(!pg_data[7], tog);
      else if (er_act && er_sus && rd_sec == er_sec)
         rdata = status_word(1'b0, tog);
      else
         rdata = arr_rd;
   end

endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        ce_n,
   input logic        oe_n,
   input logic [15:0] rdata,
   input logic        pg_act,
   input logic        pg_sus,
   input logic        er_act,
   input logic        er_sus,
   input logic        tog
);
   p_quiet_bus_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_n || oe_n) |-> rdata == 16'h0000);

   p_single_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(pg_act && !pg_sus && er_act && !er_sus));

   p_nest_only_suspended_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pg_act && er_act) |-> er_sus);

   p_status_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n && !oe_n && pg_act && !pg_sus) |-> (rdata[15:8] == 8'h00 && rdata[5:0] == 6'h00));

   p_erase_dq7_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n && !oe_n && er_act && !er_sus && !pg_act) |-> !rdata[7]);

   p_tog_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !((pg_act && !pg_sus) || (er_act && !er_sus)) |=> $stable(tog));

   p_suspend_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (pg_act && pg_sus) |=> pg_act);
endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .ce_n   (ce_n),
   .oe_n   (oe_n),
   .rdata  (rdata),
   .pg_act (pg_act),
   .pg_sus (pg_sus),
   .er_act (er_act),
   .er_sus (er_sus),
   .tog    (tog)
);

// File: tb/tb_flash_cmd_ctrl.sv
module tb_flash_cmd_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int NSEC  = 4;
   localparam int NWRD  = 8;
   localparam int PROG  = 16;
   localparam int ERASE = 60;
   localparam int PROT  = 8;
   localparam int WORDS = NSEC * NWRD;
   localparam int AW    = 5;
   localparam logic [AW-1:0] UA = 5'h15;
   localparam logic [AW-1:0] UB = 5'h0A;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, wp_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;

   int n_run = 0;
   int n_fail = 0;
   bit finished = 1'b0;
   logic [15:0] mdl [WORDS];

   always #(CLK_PERIOD/2) clk = ~clk;

   flash_cmd_ctrl #(
      .SECTORS(NSEC), .SECTOR_WORDS(NWRD), .PROG_CYCLES(PROG),
      .ERASE_CYCLES(ERASE), .PROT_CYCLES(PROT), .WP_LAST(1'b0)
   ) dut (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
      .wp_n(wp_n), .addr(addr), .wdata(wdata), .rdata(rdata)
   );

   task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
      @(negedge clk); addr = a; wdata = d; ce_n = 1'b0; we_n = 1'b0;
      @(negedge clk); we_n = 1'b1;
      @(negedge clk); ce_n = 1'b1;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [15:0] v);
      @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0;
      @(negedge clk); v = rdata; oe_n = 1'b1;
      @(negedge clk); ce_n = 1'b1;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic prog4(input logic [AW-1:0] a, input logic [15:0] d);
      wr(UA, 16'h00AA); wr(UB, 16'h0055); wr(UA, 16'h00A0); wr(a, d);
   endtask

   task automatic erase(input int sec);
      wr(UA, 16'h00AA); wr(UB, 16'h0055); wr(UA, 16'h0080);
      wr(UA, 16'h00AA); wr(UB, 16'h0055); wr(AW'(sec * NWRD + 3), 16'h0030);
   endtask

   task automatic sweep(input string tag);
      logic [15:0] v;
      for (int i = 0; i < WORDS; i++) begin
         rd(AW'(i), v);
         chk(tag, v, mdl[i]);
      end
   endtask

   function automatic logic [15:0] pat(input int i, input int k);
      return 16'((i * 16'h0F1D) ^ (k * 16'h3C5A) ^ 16'hB7E2);
   endfunction

   function automatic logic [15:0] stat(input logic [15:0] d);
      return {8'h00, ~d[7], 7'h00};
   endfunction

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         n_run++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin : main
      logic [15:0] v, v2, d;
      for (int i = 0; i < WORDS; i++) mdl[i] = 16'hFFFF;
      idle(5);
      rst_n = 1'b1;
      idle(3);

      // R1: erased start, quiet bus
      sweep("R1 erased power-up");
      @(negedge clk); addr = 5'd3; ce_n = 1'b0; oe_n = 1'b1;
      @(negedge clk); chk("R1 oe_n high gives zero", rdata, 16'h0000);
      ce_n = 1'b1;

      // R2/R6/R7: four-cycle program of sector 1
      for (int w = 0; w < NWRD; w++) begin
         d = pat(w, 1);
         prog4(AW'(NWRD + w), d);
         rd(AW'(NWRD + w), v);
         chk("R6 program status", v & 16'hFFBF, stat(d));
         rd(AW'(2 * NWRD), v2);
         chk("R7 toggle on next read", {15'h0, v2[6]}, {15'h0, ~v[6]});
         idle(PROG + 4);
         mdl[NWRD + w] = mdl[NWRD + w] & d;
         rd(AW'(NWRD + w), v);
         chk("R2 programmed word", v, mdl[NWRD + w]);
      end
      // R2: second program ANDs
      for (int w = 0; w < NWRD; w++) begin
         d = pat(w, 2);
         prog4(AW'(NWRD + w), d);
         idle(PROG + 4);
         mdl[NWRD + w] = mdl[NWRD + w] & d;
      end
      sweep("R2 AND accumulation");

      // R3: broken sequences
      wr(UA, 16'h00AA); wr(UA, 16'h0055); wr(UA, 16'h00A0); wr(5'd0, 16'h1234);
      rd(5'd0, v);
      chk("R3 wrong unlock address", v, mdl[0]);
      wr(UA, 16'h00AA); wr(UB, 16'h0055); wr(UA, 16'h0077); wr(5'd1, 16'h0000);
      rd(5'd1, v);
      chk("R3 unknown command", v, mdl[1]);
      idle(PROG + 4);
      sweep("R3 array untouched");

      // R4: bypass programming of sector 2
      wr(UA, 16'h00AA); wr(UB, 16'h0055); wr(UA, 16'h0020);
      for (int w = 0; w < NWRD; w++) begin
         d = pat(w, 3);
         wr(5'd0, 16'h00A0); wr(AW'(2 * NWRD + w), d);
         idle(PROG + 4);
         mdl[2 * NWRD + w] = mdl[2 * NWRD + w] & d;
      end
      wr(5'd0, 16'h0090); wr(5'd0, 16'h0000);
      sweep("R4 bypass programs");
      wr(5'd0, 16'h00A0); wr(AW'(3 * NWRD), 16'h0000);
      idle(PROG + 4);
      rd(AW'(3 * NWRD), v);
      chk("R4 two-write program after exit", v, mdl[3 * NWRD]);

      // R5/R6: erase sector 1
      erase(1);
      rd(AW'(3 * NWRD + 1), v);
      chk("R6 erase status other sector", v & 16'hFFBF, 16'h0000);
      idle(ERASE + 4);
      for (int w = 0; w < NWRD; w++) mdl[NWRD + w] = 16'hFFFF;
      sweep("R5 sector erase");

      // R8/R9: erase suspend with nested program
      erase(2);
      wr(5'd0, 16'h00B0);
      rd(AW'(2 * NWRD), v);
      rd(AW'(2 * NWRD + 4), v2);
      chk("R8 suspended sector status", v & 16'hFFBF, 16'h0000);
      chk("R7 DQ6 frozen while suspended", {15'h0, v2[6]}, {15'h0, v[6]});
      rd(AW'(3 * NWRD + 1), v);
      chk("R8 other sector readable", v, mdl[3 * NWRD + 1]);
      d = 16'h5A0F;
      prog4(AW'(3 * NWRD + 2), d);
      idle(PROG + 4);
      mdl[3 * NWRD + 2] = mdl[3 * NWRD + 2] & d;
      rd(AW'(3 * NWRD + 2), v);
      chk("R8 program during erase suspend", v, mdl[3 * NWRD + 2]);
      rd(AW'(2 * NWRD + 1), v);
      chk("R8 erase still suspended", v & 16'hFFBF, 16'h0000);
      wr(5'd0, 16'h0030);
      idle(ERASE + 4);
      for (int w = 0; w < NWRD; w++) mdl[2 * NWRD + w] = 16'hFFFF;
      sweep("R9 erase resumed");

      // R10: program suspend / resume
      d = 16'h0F70;
      prog4(AW'(3 * NWRD + 4), d);
      wr(5'd0, 16'h00B0);
      rd(5'd2, v);
      chk("R10 other sector readable", v, mdl[2]);
      rd(AW'(3 * NWRD + 4), v);
      rd(AW'(3 * NWRD + 5), v2);
      chk("R10 suspended program status", v & 16'hFFBF, stat(d));
      chk("R10 DQ6 held while suspended", {15'h0, v2[6]}, {15'h0, v[6]});
      idle(PROG + 4);
      rd(AW'(3 * NWRD + 4), v);
      chk("R10 no commit while suspended", v & 16'hFFBF, stat(d));
      wr(5'd0, 16'h0030);
      idle(PROG + 4);
      mdl[3 * NWRD + 4] = mdl[3 * NWRD + 4] & d;
      rd(AW'(3 * NWRD + 4), v);
      chk("R10 program resumed", v, mdl[3 * NWRD + 4]);

      // R11: write protect of sector 0
      prog4(5'd1, 16'h1234);
      idle(PROG + 4);
      mdl[1] = mdl[1] & 16'h1234;
      wp_n = 1'b0;
      prog4(5'd3, 16'h0000);
      rd(5'd3, v);
      chk("R11 protected program busy", v & 16'hFFBF, stat(16'h0000));
      idle(PROT + 4);
      rd(5'd3, v);
      chk("R11 protected program no change", v, mdl[3]);
      erase(0);
      rd(5'd0, v);
      chk("R11 protected erase busy", v & 16'hFFBF, 16'h0000);
      idle(PROT + 4);
      sweep("R11 protected erase no change");
      d = 16'h00FF;
      prog4(AW'(NWRD), d);
      idle(PROG + 4);
      mdl[NWRD] = mdl[NWRD] & d;
      rd(AW'(NWRD), v);
      chk("R11 unprotected sector programs", v, mdl[NWRD]);
      wp_n = 1'b1;

      // R12: reset aborts erase and leaves bypass
      erase(3);
      idle(5);
      @(negedge clk); rst_n = 1'b0;
      idle(2);
      rst_n = 1'b1;
      idle(2);
      sweep("R12 erase aborted");
      wr(UA, 16'h00AA); wr(UB, 16'h0055); wr(UA, 16'h0020);
      @(negedge clk); rst_n = 1'b0;
      idle(2);
      rst_n = 1'b1;
      wr(5'd0, 16'h00A0); wr(AW'(3 * NWRD + 6), 16'h0000);
      idle(PROG + 4);
      rd(AW'(3 * NWRD + 6), v);
      chk("R12 bypass cleared by reset", v, mdl[3 * NWRD + 6]);
      d = 16'h7E81;
      prog4(AW'(3 * NWRD + 7), d);
      idle(PROG + 4);
      mdl[3 * NWRD + 7] = mdl[3 * NWRD + 7] & d;
      sweep("R12 commands after reset");

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule